// File: doc/BRIEF.md
# Three-Phase Sine-Weighted PWM Modulator

This block drives the six switch enables of a three-phase bridge so that each phase leg sees a pulse-width-modulated voltage whose duty follows a sine curve. A 16-bit phase accumulator advances by a commanded step every clock cycle. Three table lookups, 120 electrical degrees apart, give each phase its sine position. A 9-bit speed demand scales how far the duty swings around 50 %, and a 9-bit up-counting carrier turns each phase duty into high-side and low-side enables, with a dead cycle between them.

Two features support a sensorless motor loop. Around each zero crossing of phase A, the block opens a short sensing window: phase A floats (both of its switches are off) so that an external comparator can observe back-EMF, and a window flag marks the interval. A speed output completes one period per electrical revolution. An overcurrent flag removes all high-side drive until the current carrier period ends. All inputs are plain control pins that are sampled every clock. No data stream crosses the block's edge, so no handshake or back-pressure applies.

Top module: `sine_pwm_modulator`

## Requirements
- R1: While `rst_n` is low, and from the first clock edge at which `en_i` is sampled low, all six switch enables, `win_o` and `fg_o` are 0. The phase accumulator and the carrier are held at zero, and every latched duty is reset to mid-scale (256).
- R2: At each enabled edge the accumulator adds `step_i` modulo 2^16. Phase A indexes the table with the top 8 bits of the accumulator. Phases B and C use the top 8 bits of (accumulator − 21845) and (accumulator − 43691), both taken modulo 2^16.
- R3: The 256-entry sine table holds 8-bit codes. For index i, let h = i mod 128, p = h·(128−h) and m = floor(508·p / (20480−p)). The entry is 128+m for i < 128 and 128−m otherwise.
- R4: The duty of a phase is 256 + floor((code−128)·demand / 512), computed with an arithmetic shift and clamped to 0..511. It is latched at the edge where the carrier leaves 511, and it stays in force for the whole following carrier period. The first period after enable uses 256.
- R5: The carrier is a 9-bit counter that starts at 0 after enable and increments on every enabled edge, wrapping from 511 to 0. A phase requests its high side while carrier < duty and its low side otherwise. The enables are registered, so they reflect the request of the preceding cycle.
- R6: The high-side and low-side enables of one phase are never 1 together. A switch turns on only if its partner was off in the previous cycle, which gives one dead cycle on every transition.
- R7: The window is open while the low 15 bits of the accumulator are below WIN_W (default 512), that is, just after 0 and just after 180 degrees. `win_o` shows it one cycle later. While the window is open, phase A requests neither switch.
- R8: A cycle with `oc_i` high withdraws every high-side request in that cycle and in every remaining cycle of the current carrier period, up to and including carrier value 511. From the next carrier value 0 on, the high-side requests depend only on the duty comparison and `oc_i`. Low-side requests are unaffected.
- R9: `fg_o` is 1 while the accumulator was below 32768 in the previous cycle (0 to 180 degrees) and 0 otherwise. It therefore completes one period per electrical revolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Modulator enable; low clears and silences the block |
| demand_i | input | 9 | Unsigned speed demand scaling the sine swing |
| step_i | input | 16 | Phase accumulator increment per cycle (electrical frequency) |
| oc_i | input | 1 | Overcurrent-limit flag |
| hs_o | output | 3 | High-side enables, bit 0 = phase A, 1 = B, 2 = C |
| ls_o | output | 3 | Low-side enables, same bit order |
| win_o | output | 1 | Phase-A back-EMF sensing window open |
| fg_o | output | 1 | Speed output, one period per electrical revolution |

## Verification
Each output depends on the input and on the state one rising edge earlier. This holds for the enables after a change of `oc_i` or `en_i`, and for `win_o` and `fg_o` after the accumulator crosses a threshold. A change of `demand_i` or `step_i` reaches the duties only at the next carrier wrap, so its effect can first be seen up to 512 cycles later. The bench keeps a behavioural model that advances on each rising edge from the inputs it applied. It compares every output on the following falling edge, so both the one-cycle lags and the period-boundary latching are checked cycle by cycle.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  typedef enum logic [1:0] {
    LEG_FLOAT = 2'd0,
    LEG_LOW   = 2'd1,
    LEG_HIGH  = 2'd2
  } leg_req_e;

  // Sine code for one table index: rational half-wave approximation,
  // mid-scale for zero, positive half first.
  function automatic int unsigned sine_code(input int unsigned idx,
                                            input int unsigned addr_w,
                                            input int unsigned data_w);
    int unsigned half, h, p, den, amp, mid, m;
    half = 1 << (addr_w - 1);
    h    = idx % half;
    p    = h * (half - h);
    den  = (5 * half * half) / 4 - p;
    amp  = (1 << (data_w - 1)) - 1;
    mid  = 1 << (data_w - 1);
    m    = (amp * 4 * p) / den;
    return (idx < half) ? (mid + m) : (mid - m);
  endfunction

endpackage

// File: rtl/spwm_phase_acc.sv
module spwm_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [ACC_W-1:0] step_i,
  output logic [ACC_W-1:0] acc_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_o <= '0;
    else if (!en_i) acc_o <= '0;
    else            acc_o <= acc_o + step_i;
  end

endmodule

// File: rtl/spwm_carrier.sv
module spwm_carrier #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (!en_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end

  assign last_o = &cnt_o;

endmodule

// File: rtl/spwm_duty_calc.sv
module spwm_duty_calc
  import spwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SIN_W  = 8,
  parameter int DEM_W  = 9,
  parameter int CNT_W  = 9
) (
  input  logic [ADDR_W-1:0] idx_i,
  input  logic [DEM_W-1:0]  demand_i,
  output logic [CNT_W-1:0]  duty_o
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PROD_W = SIN_W + 1 + DEM_W + 1;
  localparam logic [SIN_W-1:0]        SIN_MID = SIN_W'(1 << (SIN_W - 1));
  localparam logic signed [PROD_W:0]  DUTY_MID = (PROD_W + 1)'(1 << (CNT_W - 1));
  localparam logic signed [PROD_W:0]  DUTY_MAX = (PROD_W + 1)'((1 << CNT_W) - 1);

  logic [SIN_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = SIN_W'(sine_code(g, ADDR_W, SIN_W));
  end

  logic [SIN_W-1:0]         code;
  logic signed [SIN_W:0]    off_s;
  logic signed [DEM_W:0]    dem_s;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;
  logic signed [PROD_W:0]   sum;

  assign code   = rom[idx_i];
  assign off_s  = $signed({1'b0, code}) - $signed({1'b0, SIN_MID});
  assign dem_s  = $signed({1'b0, demand_i});
  assign prod   = off_s * dem_s;
  assign scaled = prod >>> DEM_W;
  assign sum    = DUTY_MID + scaled;

  always_comb begin
    if (sum[PROD_W])          duty_o = '0;
    else if (sum > DUTY_MAX)  duty_o = '1;
    else                      duty_o = sum[CNT_W-1:0];
  end

endmodule

// File: rtl/spwm_gate_stage.sv
module spwm_gate_stage
  import spwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_i,
  input  leg_req_e req_i,
  output logic     hs_o,
  output logic     ls_o
);

  // A switch may close only after its partner has been open for a cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_o <= 1'b0;
      ls_o <= 1'b0;
    end else if (!en_i) begin
      hs_o <= 1'b0;
      ls_o <= 1'b0;
    end else begin
      hs_o <= (req_i == LEG_HIGH) && !ls_o;
      ls_o <= (req_i == LEG_LOW)  && !hs_o;
    end
  end

endmodule

// File: rtl/sine_pwm_modulator.sv
module sine_pwm_modulator
  import spwm_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int ADDR_W = 8,
  parameter int SIN_W  = 8,
  parameter int CNT_W  = 9,
  parameter int DEM_W  = 9,
  parameter int WIN_W  = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DEM_W-1:0] demand_i,
  input  logic [ACC_W-1:0] step_i,
  input  logic             oc_i,
  output logic [2:0]       hs_o,
  output logic [2:0]       ls_o,
  output logic             win_o,
  output logic             fg_o
);

  localparam int PHASES = 3;
  localparam logic [ACC_W-1:0] WIN_L    = ACC_W'(WIN_W);
  localparam logic [CNT_W-1:0] DUTY_RST = CNT_W'(1 << (CNT_W - 1));

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             period_end;
  logic             win_c;
  logic             oc_hold;
  logic             hs_block;

  spwm_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .step_i (step_i),
    .acc_o  (acc_q)
  );

  spwm_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .cnt_o  (cnt_q),
    .last_o (period_end)
  );

  // Sensing window just after each zero crossing of phase A.
  assign win_c = {1'b0, acc_q[ACC_W-2:0]} < WIN_L;

  // Overcurrent cutoff latched until the carrier period closes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  oc_hold <= 1'b0;
    else if (!en_i || period_end) oc_hold <= 1'b0;
    else                         oc_hold <= oc_hold | oc_i;
  end

  assign hs_block = oc_i | oc_hold;

  for (genvar g = 0; g < PHASES; g++) begin : g_phase
    localparam int unsigned OFS = ((g * (1 << ACC_W)) + 1) / 3;
    localparam logic [ACC_W-1:0] OFS_L = ACC_W'(OFS);

    logic [ACC_W-1:0] ph;
    logic [CNT_W-1:0] duty_c;
    logic [CNT_W-1:0] duty_q;
    leg_req_e         req;
    logic             floats;
    logic             unused_ph_low;

    assign ph            = acc_q - OFS_L;
    assign unused_ph_low = ^ph[ACC_W-ADDR_W-1:0];

    spwm_duty_calc #(
      .ADDR_W (ADDR_W),
      .SIN_W  (SIN_W),
      .DEM_W  (DEM_W),
      .CNT_W  (CNT_W)
    ) u_duty (
      .idx_i    (ph[ACC_W-1 -: ADDR_W]),
      .demand_i (demand_i),
      .duty_o   (duty_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          duty_q <= DUTY_RST;
      else if (!en_i)      duty_q <= DUTY_RST;
      else if (period_end) duty_q <= duty_c;
    end

    if (g == 0) begin : g_sense
      assign floats = win_c;
    end else begin : g_plain
      assign floats = 1'b0;
    end

    always_comb begin
      if (floats)              req = LEG_FLOAT;
      else if (cnt_q < duty_q) req = hs_block ? LEG_FLOAT : LEG_HIGH;
      else                     req = LEG_LOW;
    end

    spwm_gate_stage u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (en_i),
      .req_i (req),
      .hs_o  (hs_o[g]),
      .ls_o  (ls_o[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_o <= 1'b0;
      fg_o  <= 1'b0;
    end else if (!en_i) begin
      win_o <= 1'b0;
      fg_o  <= 1'b0;
    end else begin
      win_o <= win_c;
      fg_o  <= ~acc_q[ACC_W-1];
    end
  end

endmodule

// File: rtl/spwm_checker.sv
module spwm_checker #(
  parameter int ACC_W = 16,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             oc_i,
  input logic [ACC_W-1:0] step_i,
  input logic [ACC_W-1:0] acc_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [2:0]       hs_o,
  input logic [2:0]       ls_o,
  input logic             win_o,
  input logic             fg_o
);

  AST_LEGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_o & ls_o) == 3'b000); // R6

  AST_DEAD_BEFORE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_o & $past(ls_o)) == 3'b000); // R6

  AST_DEAD_BEFORE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_o & $past(hs_o)) == 3'b000); // R6

  AST_WINDOW_FLOATS_A: assert property (@(posedge clk) disable iff (!rst_n)
    win_o |-> (!hs_o[0] && !ls_o[0])); // R7

  AST_OC_CUTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    oc_i |=> (hs_o == 3'b000)); // R8

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (hs_o == 3'b000 && ls_o == 3'b000 && !win_o && !fg_o
               && acc_q == '0 && cnt_q == '0)); // R1

  AST_ACC_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (acc_q == ACC_W'($past(acc_q) + $past(step_i)))); // R2

  AST_CARRIER_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R5

  AST_FG_HALF_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (fg_o == !$past(acc_q[ACC_W-1]))); // R9

endmodule

bind sine_pwm_modulator spwm_checker #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_spwm_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en_i   (en_i),
  .oc_i   (oc_i),
  .step_i (step_i),
  .acc_q  (acc_q),
  .cnt_q  (cnt_q),
  .hs_o   (hs_o),
  .ls_o   (ls_o),
  .win_o  (win_o),
  .fg_o   (fg_o)
);

// File: tb/sine_pwm_modulator_tb.sv
`timescale 1ns/1ps
module sine_pwm_modulator_tb_top;

  localparam int WIN = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic [8:0]  demand_i = '0;
  logic [15:0] step_i = '0;
  logic        oc_i = 1'b0;
  logic [2:0]  hs_o, ls_o;
  logic        win_o, fg_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sine_pwm_modulator dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .demand_i (demand_i),
    .step_i   (step_i),
    .oc_i     (oc_i),
    .hs_o     (hs_o),
    .ls_o     (ls_o),
    .win_o    (win_o),
    .fg_o     (fg_o)
  );

  // ---------------- reference model ----------------
  int m_acc, m_cnt, m_hold;
  int m_duty [3];
  bit [2:0] m_hs, m_ls;
  bit m_win, m_fg, m_last_en, m_last_blk;
  bit [2:0] prev_hs, prev_ls;
  int ofs [3] = '{0, 21845, 43691};

  function automatic int sine_ref(int i);
    int h, p, m;
    h = i % 128;
    p = h * (128 - h);
    m = (508 * p) / (20480 - p);
    return (i < 128) ? 128 + m : 128 - m;
  endfunction

  function automatic int duty_ref(int idx, int dem);
    int d;
    d = 256 + (((sine_ref(idx) - 128) * dem) >>> 9);
    if (d < 0) d = 0;
    if (d > 511) d = 511;
    return d;
  endfunction

  task automatic model_clear();
    m_acc = 0; m_cnt = 0; m_hold = 0;
    for (int k = 0; k < 3; k++) m_duty[k] = 256;
    m_hs = '0; m_ls = '0; m_win = 0; m_fg = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_clear();
      m_last_en = 0;
      m_last_blk = 0;
    end else begin
      m_last_en = en_i;
      if (!en_i) begin
        model_clear();
        m_last_blk = 0;
      end else begin
        bit win_c, blk;
        bit [2:0] n_hs, n_ls;
        win_c = (m_acc % 32768) < WIN;
        blk = oc_i || (m_hold != 0);
        m_last_blk = blk;
        for (int k = 0; k < 3; k++) begin
          bit want_hi, want_lo;
          if (k == 0 && win_c) begin
            want_hi = 0; want_lo = 0;
          end else if (m_cnt < m_duty[k]) begin
            want_hi = !blk; want_lo = 0;
          end else begin
            want_hi = 0; want_lo = 1;
          end
          n_hs[k] = want_hi && !m_ls[k];
          n_ls[k] = want_lo && !m_hs[k];
        end
        m_hs = n_hs; m_ls = n_ls;
        m_win = win_c;
        m_fg = (m_acc < 32768);
        if (m_cnt == 511) begin
          for (int k = 0; k < 3; k++)
            m_duty[k] = duty_ref(((m_acc - ofs[k]) & 16'hffff) >> 8, demand_i);
          m_hold = 0;
        end else begin
          m_hold = (m_hold != 0 || oc_i) ? 1 : 0;
        end
        m_acc = (m_acc + step_i) & 16'hffff;
        m_cnt = (m_cnt + 1) & 511;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    string t_leg;
    if (!m_last_en)      t_leg = "R1";
    else if (m_win)      t_leg = "R7";
    else if (m_last_blk) t_leg = "R8";
    else                 t_leg = "R2 R3 R4 R5";
    chk(hs_o == m_hs, {t_leg, " high-side"}, hs_o, m_hs);
    chk(ls_o == m_ls, {t_leg, " low-side"}, ls_o, m_ls);
    chk((hs_o & ls_o) == 3'b000, "R6 overlap", hs_o & ls_o, 0);
    chk(((hs_o & prev_ls) | (ls_o & prev_hs)) == 3'b000, "R6 dead cycle",
        (hs_o & prev_ls) | (ls_o & prev_hs), 0);
    chk(win_o == m_win, m_last_en ? "R7 window" : "R1 window", win_o, m_win);
    chk(fg_o == m_fg, m_last_en ? "R9 fg" : "R1 fg", fg_o, m_fg);
    prev_hs = hs_o;
    prev_ls = ls_o;
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    prev_hs = '0;
    prev_ls = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(hs_o == 0 && ls_o == 0 && !win_o && !fg_o, "R1 reset",
        {hs_o, ls_o, win_o, fg_o}, 0);
    rst_n = 1'b1;
    repeat (4) tick();

    // Full demand, moderate speed, short overcurrent pulses (R8)
    en_i = 1'b1; demand_i = 9'd511; step_i = 16'd300;
    for (int i = 0; i < 3000; i++) begin
      tick();
      oc_i = (i % 700 == 350) || (i % 1100 == 90);
    end
    oc_i = 1'b0;

    // Zero demand: fixed mid-scale duty (R4)
    demand_i = 9'd0; step_i = 16'd1200;
    for (int i = 0; i < 1200; i++) tick();

    // Slow rotation: wide sensing window (R7)
    demand_i = 9'd200; step_i = 16'd37;
    for (int i = 0; i < 4000; i++) tick();

    // Disable: outputs and state cleared (R1)
    en_i = 1'b0;
    for (int i = 0; i < 20; i++) tick();

    // Fast step, long overcurrent spanning several periods (R8)
    en_i = 1'b1; demand_i = 9'd350; step_i = 16'd5000;
    for (int i = 0; i < 2000; i++) begin
      tick();
      oc_i = (i >= 700 && i < 1300);
    end
    oc_i = 1'b0;
    demand_i = 9'd1; step_i = 16'd65000;
    for (int i = 0; i < 1100; i++) tick();

    done = 1;
    summary();
    $finish;
  end

endmodule